// File: doc/BRIEF.md
# Click-Free Volume and Mute Sequencer

This block decides when a new loudness setting and a new mute state reach the main listening path: the TV, phono and mono outputs. Software-visible settings arrive as plain levels: a mute request, a 3-bit coarse attenuation code, a 3-bit fine attenuation code and an enable for zero-crossing gating. A pulse from an external signal comparator marks each zero crossing of the audio. With gating off, every change lands on the next clock edge. With gating on, changes wait for the next zero crossing, so the analog attenuator never steps while the signal is large. This keeps the audible click small.

A hardware mute pin bypasses all of this and silences every audio output at once, including the recorder outputs that the register mute never touches. After a register mute has been applied, an optional guard timer keeps the path muted for a minimum hold time (540 µs by default at 50 MHz). This leaves room for source-switch transients to settle before the path is unmuted. A sticky status flag reports that a zero crossing has been seen since gating was enabled.

Top module: `zc_vol_ctrl`

## Requirements
- R1: With gate_en low, a change of req_mute or of the attenuation codes appears on the outputs on the first clock edge after the change, subject to R8 for unmuting.
- R2: With gate_en high, the applied mute state and attenuation do not change on any edge where zc_pulse is low. They take the requested values on an edge where zc_pulse is high.
- R3: atten_o equals coarse × 8 + fine. The coarse code occupies atten_o[5:3] and the fine code occupies atten_o[2:0], giving 0 to 63 dB in 1 dB units.
- R4: Requests that change several times while a change is waiting are not queued. The values present at the committing edge are the ones applied.
- R5: zc_status_o is set by an edge where gate_en and zc_pulse are both high. It stays set while gate_en stays high. It is cleared by the first edge with gate_en low, and zc_pulse alone never sets it while gate_en is low.
- R6: While hw_mute is high, tv_mute_o and rec_mute_o are both high in the same cycle, with no clock edge needed. Releasing hw_mute returns tv_mute_o to the register-controlled state, which hw_mute has not altered.
- R7: rec_mute_o follows hw_mute only. The register mute never drives it.
- R8: Once a register mute is applied, an unmute is not applied until GUARD_CYCLES clock edges have passed. With gating on, the unmute then waits for the next zero crossing after that.
- R9: Synchronous active-low reset leaves the path unmuted with attenuation 0, the status flag clear and the guard timer idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_mute | input | 1 | Requested register mute for the main path |
| req_coarse | input | 3 | Requested coarse attenuation code (8 dB per step) |
| req_fine | input | 3 | Requested fine attenuation code (1 dB per step) |
| gate_en | input | 1 | High: commit changes only on zero crossings |
| zc_pulse | input | 1 | One-cycle pulse per detected zero crossing |
| hw_mute | input | 1 | Hardware mute, silences all outputs at once |
| tv_mute_o | output | 1 | Mute applied to TV, phono and mono outputs |
| rec_mute_o | output | 1 | Mute applied to recorder outputs |
| atten_o | output | 6 | Applied total attenuation in dB |
| zc_status_o | output | 1 | A zero crossing occurred since gating was enabled |

## Verification
The main function is tried with gating off, where each step must show up one edge later, and with gating on and no crossings, where nothing may move. These two patterns separate a commit term that ignores the gate from one that ignores the pulse. A burst of changing requests followed by one crossing shows that only the latest values are applied. Mute and unmute requests placed inside and just beyond the guard window separate an early release from a lost one. Hardware-mute pulses are checked before any clock edge, which separates a combinational bypass from a registered one.

// File: rtl/zcv_pkg.sv
// Shared types and helpers for the zero-cross volume/mute sequencer.
// Assumes attenuation is coarse and fine codes joined, coarse on top.
package zcv_pkg;

    // Register-mute state of the main audio path
    typedef enum logic {
        MS_OPEN  = 1'b0,
        MS_MUTED = 1'b1
    } mute_state_e;

    // Total attenuation from coarse and fine codes; coarse weight is 2**FW
    function automatic logic [5:0] join_atten(input logic [2:0] coarse,
                                              input logic [2:0] fine);
        return {coarse, fine};
    endfunction

endpackage

// File: rtl/zcv_zc_tracker.sv
// Commit decision and zero-cross status flag.
// Assumes zc_pulse is already synchronous and one cycle wide per crossing.
module zcv_zc_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_en,
    input  logic zc_pulse,
    output logic commit,
    output logic zc_status
);

    // Changes pass when gating is off, or on a crossing when it is on
    always_comb begin
        commit = !gate_en || zc_pulse;
    end

    // Sticky flag: set by a crossing under gating, cleared when gating drops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zc_status <= 1'b0;
        end else if (!gate_en) begin
            zc_status <= 1'b0;
        end else if (zc_pulse) begin
            zc_status <= 1'b1;
        end
    end

endmodule

// File: rtl/zcv_guard_timer.sv
// Minimum mute hold timer. Loaded when a register mute is applied,
// counts down each clock; busy while the hold window is still open.
// Assumes GUARD_CYCLES >= 1; GUARD_EN = 0 makes the window empty.
module zcv_guard_timer #(
    parameter bit          GUARD_EN     = 1'b1,
    parameter int unsigned GUARD_CYCLES = 27000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int unsigned CNT_W = $clog2(GUARD_CYCLES + 1);
    localparam int unsigned LOAD  = GUARD_EN ? (GUARD_CYCLES - 1) : 0;

    logic [CNT_W-1:0] cnt_q;

    // Load on mute application, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(LOAD);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Window open while the count has not reached zero
    always_comb begin
        busy = (cnt_q != '0);
    end

endmodule

// File: rtl/zcv_mute_fsm.sv
// Register-mute state machine. Applies mute on commit, and applies
// unmute on commit only once the guard window has closed.
// Assumes commit already folds in the zero-cross gating.
module zcv_mute_fsm
    import zcv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    input  logic req_mute,
    input  logic guard_busy,
    output logic soft_mute,
    output logic guard_start
);

    mute_state_e state_q, state_d;

    // Next state and guard load request
    always_comb begin
        state_d     = state_q;
        guard_start = 1'b0;
        unique case (state_q)
            MS_OPEN: begin
                if (commit && req_mute) begin
                    state_d     = MS_MUTED;
                    guard_start = 1'b1;
                end
            end
            MS_MUTED: begin
                if (commit && !req_mute && !guard_busy) begin
                    state_d = MS_OPEN;
                end
            end
            default: state_d = MS_OPEN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MS_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Applied register mute
    always_comb begin
        soft_mute = (state_q == MS_MUTED);
    end

endmodule

// File: rtl/zcv_vol_reg.sv
// Applied attenuation register, updated from the request on commit.
// Assumes coarse step equals 2**FINE_W fine steps.
module zcv_vol_reg #(
    parameter int unsigned COARSE_W = 3,
    parameter int unsigned FINE_W   = 3,
    localparam int unsigned ATT_W   = COARSE_W + FINE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  logic [COARSE_W-1:0] req_coarse,
    input  logic [FINE_W-1:0]   req_fine,
    output logic [ATT_W-1:0]    atten
);

    logic [ATT_W-1:0] total_d;

    // Total attenuation of the request: coarse weighted above fine
    always_comb begin
        total_d = {req_coarse, req_fine};
    end

    // Capture latest request on each commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            atten <= '0;
        end else if (commit) begin
            atten <= total_d;
        end
    end

endmodule

// File: rtl/zc_vol_ctrl.sv
// Top of the zero-cross gated volume and mute sequencer.
// Register settings are applied at once or on a zero crossing; the
// hardware mute bypasses all state and acts combinationally.
// Assumes all inputs are synchronous to clk.
module zc_vol_ctrl #(
    parameter int unsigned COARSE_W     = 3,
    parameter int unsigned FINE_W       = 3,
    parameter bit          GUARD_EN     = 1'b1,
    parameter int unsigned GUARD_CYCLES = 27000,
    localparam int unsigned ATT_W       = COARSE_W + FINE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_mute,
    input  logic [COARSE_W-1:0] req_coarse,
    input  logic [FINE_W-1:0]   req_fine,
    input  logic                gate_en,
    input  logic                zc_pulse,
    input  logic                hw_mute,
    output logic                tv_mute_o,
    output logic                rec_mute_o,
    output logic [ATT_W-1:0]    atten_o,
    output logic                zc_status_o
);

    logic commit;
    logic soft_mute;
    logic guard_start;
    logic guard_busy;

    zcv_zc_tracker u_zc (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_en   (gate_en),
        .zc_pulse  (zc_pulse),
        .commit    (commit),
        .zc_status (zc_status_o)
    );

    zcv_guard_timer #(
        .GUARD_EN     (GUARD_EN),
        .GUARD_CYCLES (GUARD_CYCLES)
    ) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .start (guard_start),
        .busy  (guard_busy)
    );

    zcv_mute_fsm u_mute (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .req_mute    (req_mute),
        .guard_busy  (guard_busy),
        .soft_mute   (soft_mute),
        .guard_start (guard_start)
    );

    zcv_vol_reg #(
        .COARSE_W (COARSE_W),
        .FINE_W   (FINE_W)
    ) u_vol (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .req_coarse (req_coarse),
        .req_fine   (req_fine),
        .atten      (atten_o)
    );

    // Output mutes: hardware pin overrides everything without a clock edge
    always_comb begin
        tv_mute_o  = soft_mute | hw_mute;
        rec_mute_o = hw_mute;
    end

endmodule

// File: rtl/zcv_checker.sv
// Property checker for zc_vol_ctrl, attached by bind below.
module zcv_checker #(
    parameter int unsigned COARSE_W     = 3,
    parameter int unsigned FINE_W       = 3,
    parameter bit          GUARD_EN     = 1'b1,
    parameter int unsigned GUARD_CYCLES = 27000
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_mute,
    input logic [COARSE_W-1:0]          req_coarse,
    input logic [FINE_W-1:0]            req_fine,
    input logic                         gate_en,
    input logic                         zc_pulse,
    input logic                         hw_mute,
    input logic                         tv_mute_o,
    input logic                         rec_mute_o,
    input logic [COARSE_W+FINE_W-1:0]   atten_o,
    input logic                         zc_status_o,
    input logic                         soft_mute
);

    localparam int unsigned ATT_W = COARSE_W + FINE_W;
    localparam int unsigned HW    = $clog2(GUARD_CYCLES + 1);

    logic [HW-1:0] held_q;
    logic          prev_mute_q;

    // Cycles the register mute has been held since it rose (saturating)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q      <= '0;
            prev_mute_q <= 1'b0;
        end else begin
            prev_mute_q <= soft_mute;
            if (soft_mute && !prev_mute_q) begin
                held_q <= HW'(1);
            end else if (soft_mute && held_q < HW'(GUARD_CYCLES)) begin
                held_q <= held_q + 1'b1;
            end
        end
    end

    assert_imm_volume_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |=> atten_o == (ATT_W'($past(req_coarse)) * ATT_W'(1 << FINE_W)
                                 + ATT_W'($past(req_fine))));

    assert_imm_mute_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en && req_mute) |=> soft_mute);

    assert_hold_volume_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && !zc_pulse) |=> $stable(atten_o));

    assert_hold_mute_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && !zc_pulse) |=> $stable(soft_mute));

    assert_status_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && zc_pulse) |=> zc_status_o);

    assert_status_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |=> !zc_status_o);

    assert_hw_override_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hw_mute |-> (tv_mute_o && rec_mute_o));

    assert_rec_ignores_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_mute && soft_mute) |-> !rec_mute_o);

    generate
        if (GUARD_EN) begin : g_guard_chk
            assert_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(soft_mute) |-> held_q >= HW'(GUARD_CYCLES));
        end
    endgenerate

endmodule

bind zc_vol_ctrl zcv_checker #(
    .COARSE_W     (COARSE_W),
    .FINE_W       (FINE_W),
    .GUARD_EN     (GUARD_EN),
    .GUARD_CYCLES (GUARD_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_mute    (req_mute),
    .req_coarse  (req_coarse),
    .req_fine    (req_fine),
    .gate_en     (gate_en),
    .zc_pulse    (zc_pulse),
    .hw_mute     (hw_mute),
    .tv_mute_o   (tv_mute_o),
    .rec_mute_o  (rec_mute_o),
    .atten_o     (atten_o),
    .zc_status_o (zc_status_o),
    .soft_mute   (soft_mute)
);

// File: tb/zc_vol_ctrl_tb_top.sv
// Bench: table walk of one-cycle stimulus/expectation rows, then
// directed tests for reset and the combinational hardware mute.
module zc_vol_ctrl_tb_top;

    localparam int unsigned GUARD = 4;
    localparam int unsigned NVEC  = 21;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_mute = 1'b0;
    logic [2:0] req_coarse = '0;
    logic [2:0] req_fine = '0;
    logic       gate_en = 1'b0;
    logic       zc_pulse = 1'b0;
    logic       hw_mute = 1'b0;
    logic       tv_mute_o, rec_mute_o, zc_status_o;
    logic [5:0] atten_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    zc_vol_ctrl #(
        .GUARD_EN     (1'b1),
        .GUARD_CYCLES (GUARD)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_mute    (req_mute),
        .req_coarse  (req_coarse),
        .req_fine    (req_fine),
        .gate_en     (gate_en),
        .zc_pulse    (zc_pulse),
        .hw_mute     (hw_mute),
        .tv_mute_o   (tv_mute_o),
        .rec_mute_o  (rec_mute_o),
        .atten_o     (atten_o),
        .zc_status_o (zc_status_o)
    );

    // Row: {req[3:0], gate, zc, mute, coarse[2:0], fine[2:0], hw, exp_tv, exp_att[5:0], exp_st}
    localparam logic [21:0] VEC [NVEC] = '{
        {4'd1, 1'b0, 1'b0, 1'b0, 3'd3, 3'd5, 1'b0, 1'b0, 6'd29, 1'b0}, // R1 R3 volume at once
        {4'd1, 1'b0, 1'b0, 1'b1, 3'd3, 3'd5, 1'b0, 1'b1, 6'd29, 1'b0}, // R1 mute at once
        {4'd8, 1'b0, 1'b0, 1'b0, 3'd3, 3'd5, 1'b0, 1'b1, 6'd29, 1'b0}, // R8 guard holds
        {4'd8, 1'b0, 1'b0, 1'b0, 3'd3, 3'd5, 1'b0, 1'b1, 6'd29, 1'b0}, // R8
        {4'd8, 1'b0, 1'b0, 1'b0, 3'd3, 3'd5, 1'b0, 1'b1, 6'd29, 1'b0}, // R8 last guarded edge
        {4'd8, 1'b0, 1'b0, 1'b0, 3'd3, 3'd5, 1'b0, 1'b0, 6'd29, 1'b0}, // R8 unmute after 4
        {4'd2, 1'b1, 1'b0, 1'b0, 3'd7, 3'd7, 1'b0, 1'b0, 6'd29, 1'b0}, // R2 volume held
        {4'd4, 1'b1, 1'b0, 1'b0, 3'd2, 3'd1, 1'b0, 1'b0, 6'd29, 1'b0}, // R4 request replaced
        {4'd4, 1'b1, 1'b1, 1'b0, 3'd2, 3'd1, 1'b0, 1'b0, 6'd17, 1'b1}, // R4 R5 latest on crossing
        {4'd2, 1'b1, 1'b0, 1'b1, 3'd2, 3'd1, 1'b0, 1'b0, 6'd17, 1'b1}, // R2 mute held
        {4'd6, 1'b1, 1'b0, 1'b1, 3'd2, 3'd1, 1'b1, 1'b1, 6'd17, 1'b1}, // R6 hw mute
        {4'd6, 1'b1, 1'b0, 1'b1, 3'd2, 3'd1, 1'b0, 1'b0, 6'd17, 1'b1}, // R6 release, still pending
        {4'd2, 1'b1, 1'b1, 1'b1, 3'd0, 3'd0, 1'b0, 1'b1, 6'd0,  1'b1}, // R2 both commit on crossing
        {4'd8, 1'b1, 1'b1, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 6'd0,  1'b1}, // R8 crossing inside window
        {4'd8, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 6'd0,  1'b1}, // R8
        {4'd8, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 6'd0,  1'b1}, // R8
        {4'd8, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 6'd0,  1'b1}, // R8 window shut, no crossing
        {4'd8, 1'b1, 1'b1, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 6'd0,  1'b1}, // R8 unmute on crossing
        {4'd5, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 6'd0,  1'b0}, // R5 clear on gate off
        {4'd5, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 6'd0,  1'b0}, // R5 pulse without gate
        {4'd3, 1'b0, 1'b0, 1'b0, 3'd7, 3'd7, 1'b0, 1'b0, 6'd63, 1'b0}  // R3 full scale
    };

    task automatic check(input string req, input string what,
                         input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9", "tv_mute", int'(tv_mute_o), 0);
        check("R9", "atten", int'(atten_o), 0);
        check("R9", "status", int'(zc_status_o), 0);
        check("R7", "rec_mute", int'(rec_mute_o), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [21:0] v;
            string rq;
            v = VEC[i];
            gate_en    = v[17];
            zc_pulse   = v[16];
            req_mute   = v[15];
            req_coarse = v[14:12];
            req_fine   = v[11:9];
            hw_mute    = v[8];
            @(negedge clk);
            rq = $sformatf("R%0d", v[21:18]);
            check(rq, $sformatf("row %0d tv_mute", i), int'(tv_mute_o), int'(v[7]));
            check(rq, $sformatf("row %0d atten", i), int'(atten_o), int'(v[6:1]));
            check(rq, $sformatf("row %0d status", i), int'(zc_status_o), int'(v[0]));
            check("R7", $sformatf("row %0d rec_mute", i), int'(rec_mute_o), int'(v[8]));
        end

        // R6: hardware mute acts before any clock edge; register state kept
        zc_pulse = 1'b0;
        gate_en  = 1'b0;
        req_mute = 1'b0;
        @(negedge clk);
        hw_mute = 1'b1;
        #1;
        check("R6", "tv_mute same cycle", int'(tv_mute_o), 1);
        check("R6", "rec_mute same cycle", int'(rec_mute_o), 1);
        @(negedge clk);
        hw_mute = 1'b0;
        #1;
        check("R6", "tv_mute after release", int'(tv_mute_o), 0);
        check("R7", "rec_mute after release", int'(rec_mute_o), 0);

        // R7: register mute leaves recorder mute low
        req_mute = 1'b1;
        @(negedge clk);
        check("R7", "rec_mute under reg mute", int'(rec_mute_o), 0);
        check("R1", "tv_mute under reg mute", int'(tv_mute_o), 1);

        // R9: reset from a muted, attenuated, flagged state
        req_coarse = 3'd5;
        gate_en    = 1'b1;
        zc_pulse   = 1'b1;
        @(negedge clk);
        zc_pulse = 1'b0;
        check("R5", "status before reset", int'(zc_status_o), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", "tv_mute after reset", int'(tv_mute_o), 0);
        check("R9", "atten after reset", int'(atten_o), 0);
        check("R9", "status after reset", int'(zc_status_o), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule